// File: doc/BRIEF.md
# Oversampled Single-Wire Response Receiver

This block recovers a 32-bit response word from a bidirectional single-wire link once the request has been sent. Each bit on the wire lasts one bit period of 16 receiver clocks and always starts with a falling edge. A short low phase followed by a long high phase encodes a one. A long low phase followed by a short high phase encodes a zero. The line rests high between transfers. The receiver runs from a clock at sixteen times the bit rate. It does not shift on a free-running bit clock. Instead it restarts its timing at every falling edge, which absorbs the unknown phase and rate offset of the remote end. It then decides the bit from a single look at the line a fixed few cycles into the bit.

The surrounding controller pulses `arm_i` after it issues its request. The receiver then collects the data bits, most significant first, and waits for the edge of the trailing stop bit. It then presents the word with a one-cycle valid pulse. If the line goes quiet while a bit or the stop bit is expected, the receiver raises a one-cycle timeout and drops the transfer.

Top module: `sw_bit_receiver`

## Requirements
- R1: While reset is applied, and after it is released, `word_o` reads 0 and `valid_o` and `timeout_o` are low until a transfer is armed.
- R2: With the receiver not armed, activity on `line_i` produces no `valid_o`, no `timeout_o` and no change of `word_o`.
- R3: The receiver restarts its bit timing at each falling edge of the line. The bit value is the line level about 6 cycles after the edge: low gives 0 and high gives 1. A one is decoded correctly for low phases of 2 to 4 cycles, and a zero for low phases of 9 to 12 cycles, with bit periods from 14 to 18 cycles.
- R4: The first data bit received lands in `word_o[31]` and the last lands in `word_o[0]`.
- R5: After the 32nd data bit, the next falling edge (the stop bit) makes `valid_o` high for exactly one cycle. The new word appears on `word_o` in that same cycle and holds until the next valid pulse.
- R6: A falling edge that occurs within a bit before that bit's sample point is ignored. It neither adds a bit nor shifts the sample point.
- R7: While a data bit or the stop bit is awaited, 64 cycles without a falling edge raise `timeout_o` for one cycle. No valid pulse follows, the receiver returns to idle, and a later arm starts a fresh transfer.
- R8: An `arm_i` pulse during a transfer in progress is ignored, and the transfer completes normally.
- R9: `valid_o` and `timeout_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, 16 times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_i | input | 1 | Raw asynchronous single-wire line, idles high |
| arm_i | input | 1 | One-cycle strobe that starts a reception from idle |
| word_o | output | 32 | Last complete received word, first bit in the MSB |
| valid_o | output | 1 | One-cycle pulse when `word_o` takes a new word |
| timeout_o | output | 1 | One-cycle pulse when an awaited edge fails to arrive |

## Verification
A falling edge on the line is seen by the control logic three clocks after the bench drives it, because of two synchronizer stages and the edge-detect flop. As a result, the valid pulse for a frame appears a few cycles into the stop bit. The bench does not predict that exact cycle. A monitor samples `valid_o`, `timeout_o` and `word_o` on every falling clock edge and latches the word at each pulse. The frame checks then run after the stop bit and its settling gap, when both pulses are certainly due. The timeout is due 64 cycles after arming, plus the flop latency. It is checked against a window of 60 to 70 cycles counted from the arm strobe, and the bench checks that no valid pulse appears in that interval.

// File: rtl/sw_rx_pkg.sv
package sw_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_GAP  = 2'd1,
    RX_BIT  = 2'd2,
    RX_STOP = 2'd3
  } rx_state_e;

endpackage

// File: rtl/sw_rx_sync.sv
// Synchronizer chain for the asynchronous line plus falling-edge detector.
module sw_rx_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic fall_o
);

  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= RESET_LVL;
    else        chain_q[0] <= line_i;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= RESET_LVL;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign fall_o  = chain_q[STAGES] & ~chain_q[STAGES-1];

endmodule

// File: rtl/sw_rx_count.sv
// Up counter with synchronous clear taking priority over enable.
module sw_rx_count #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_o;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_o + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_o <= '0;
    else        cnt_o <= cnt_d;
  end

endmodule

// File: rtl/sw_rx_shift.sv
// MSB-first assembly register and output holding register.
module sw_rx_shift #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en_i,
  input  logic         bit_i,
  input  logic         load_i,
  output logic [N-1:0] word_o
);

  logic [N-1:0] acc_q, acc_d;
  logic [N-1:0] word_d;

  always_comb begin
    acc_d  = acc_q;
    word_d = word_o;
    if (shift_en_i) acc_d  = {acc_q[N-2:0], bit_i};
    if (load_i)     word_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      word_o <= '0;
    end else begin
      acc_q  <= acc_d;
      word_o <= word_d;
    end
  end

endmodule

// File: rtl/sw_bit_receiver.sv
module sw_bit_receiver
  import sw_rx_pkg::*;
#(
  parameter int DATA_BITS   = 32,
  parameter int SAMPLE_AT   = 5,
  parameter int TIMEOUT_CYC = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_i,
  input  logic                 arm_i,
  output logic [DATA_BITS-1:0] word_o,
  output logic                 valid_o,
  output logic                 timeout_o
);

  localparam int PH_W  = $clog2(SAMPLE_AT + 1);
  localparam int BIT_W = $clog2(DATA_BITS + 1);
  localparam int TO_W  = $clog2(TIMEOUT_CYC);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(SAMPLE_AT);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_BITS - 1);
  localparam logic [TO_W-1:0]  TO_LAST  = TO_W'(TIMEOUT_CYC - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // line conditioning
  logic line_lvl, line_fall;

  sw_rx_sync #(.STAGES(SYNC_STAGES), .RESET_LVL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .line_i  (line_i),
    .level_o (line_lvl),
    .fall_o  (line_fall)
  );

  // counters: phase inside a bit, bits taken, idle-wait length
  logic             ph_clr, ph_en, bc_clr, bc_en, to_clr, to_en;
  logic [PH_W-1:0]  ph_cnt;
  logic [BIT_W-1:0] bit_cnt;
  logic [TO_W-1:0]  to_cnt;

  sw_rx_count #(.W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_int_n), .clr_i(ph_clr), .en_i(ph_en), .cnt_o(ph_cnt)
  );
  sw_rx_count #(.W(BIT_W)) u_bits (
    .clk(clk), .rst_n(rst_int_n), .clr_i(bc_clr), .en_i(bc_en), .cnt_o(bit_cnt)
  );
  sw_rx_count #(.W(TO_W)) u_wait (
    .clk(clk), .rst_n(rst_int_n), .clr_i(to_clr), .en_i(to_en), .cnt_o(to_cnt)
  );

  // data path
  logic shift_en, load_word;

  sw_rx_shift #(.N(DATA_BITS)) u_shift (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .shift_en_i (shift_en),
    .bit_i      (line_lvl),
    .load_i     (load_word),
    .word_o     (word_o)
  );

  // control
  rx_state_e state_q, state_d;
  logic      valid_d, timeout_d;

  always_comb begin
    state_d   = state_q;
    ph_clr    = 1'b0;
    ph_en     = 1'b0;
    bc_clr    = 1'b0;
    bc_en     = 1'b0;
    to_clr    = 1'b0;
    to_en     = 1'b0;
    shift_en  = 1'b0;
    load_word = 1'b0;
    valid_d   = 1'b0;
    timeout_d = 1'b0;
    unique case (state_q)
      RX_IDLE: begin
        ph_clr = 1'b1;
        to_clr = 1'b1;
        if (arm_i) begin
          bc_clr  = 1'b1;
          state_d = RX_GAP;
        end
      end
      RX_GAP: begin
        if (line_fall) begin
          ph_clr  = 1'b1;
          to_clr  = 1'b1;
          state_d = RX_BIT;
        end else if (to_cnt == TO_LAST) begin
          timeout_d = 1'b1;
          state_d   = RX_IDLE;
        end else begin
          to_en = 1'b1;
        end
      end
      RX_BIT: begin
        // edges are not looked at until the sample has been taken
        if (ph_cnt == PH_LAST) begin
          shift_en = 1'b1;
          bc_en    = 1'b1;
          to_clr   = 1'b1;
          state_d  = (bit_cnt == BIT_LAST) ? RX_STOP : RX_GAP;
        end else begin
          ph_en = 1'b1;
        end
      end
      RX_STOP: begin
        if (line_fall) begin
          load_word = 1'b1;
          valid_d   = 1'b1;
          state_d   = RX_IDLE;
        end else if (to_cnt == TO_LAST) begin
          timeout_d = 1'b1;
          state_d   = RX_IDLE;
        end else begin
          to_en = 1'b1;
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q   <= RX_IDLE;
      valid_o   <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      valid_o   <= valid_d;
      timeout_o <= timeout_d;
    end
  end

endmodule

// File: rtl/sw_rx_chk.sv
module sw_rx_chk
  import sw_rx_pkg::*;
#(
  parameter int DATA_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DATA_BITS-1:0] word_o,
  input  logic                 valid_o,
  input  logic                 timeout_o,
  input  rx_state_e            state_q
);

  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(word_o));

  // R7
  timeout_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

  // R7
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (state_q == RX_IDLE));

  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && timeout_o));

  // R5
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (state_q == RX_IDLE));

endmodule

bind sw_bit_receiver sw_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .word_o    (word_o),
  .valid_o   (valid_o),
  .timeout_o (timeout_o),
  .state_q   (state_q)
);

// File: tb/tb_sw_bit_receiver.sv
module tb_sw_bit_receiver;

  localparam int NB = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          line_i;
  logic          arm_i;
  logic [NB-1:0] word_o;
  logic          valid_o;
  logic          timeout_o;

  int checks = 0;
  int errors = 0;
  int vcnt = 0;
  int tcnt = 0;
  int both = 0;
  logic [NB-1:0] vword = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sw_bit_receiver dut (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .arm_i(arm_i),
    .word_o(word_o), .valid_o(valid_o), .timeout_o(timeout_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_o) begin vcnt++; vword = word_o; end
      if (timeout_o) tcnt++;
      if (valid_o && timeout_o) both++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b, input bit jit);
    int lo, per;
    lo  = b ? 4 : 12;
    per = 16;
    if (jit) begin
      lo  = b ? 2 + int'($urandom % 3) : 9 + int'($urandom % 4);
      per = 14 + int'($urandom % 5);
    end
    line_i = 1'b0; cyc(lo);
    line_i = 1'b1; cyc(per - lo);
  endtask

  // extra falling edge early in a one bit
  task automatic send_glitch_one();
    line_i = 1'b0; cyc(2);
    line_i = 1'b1; cyc(1);
    line_i = 1'b0; cyc(1);
    line_i = 1'b1; cyc(12);
  endtask

  task automatic arm_pulse();
    arm_i = 1'b1; cyc(1);
    arm_i = 1'b0;
  endtask

  // nbits data bits, optional stop bit; mid_arm < 0 disables re-arm
  task automatic send_frame(input logic [NB-1:0] w, input int nbits, input bit stop,
                            input bit jit, input int mid_arm, input int glitch_at);
    arm_pulse();
    cyc(2);
    for (int i = 0; i < nbits; i++) begin
      if (i == mid_arm) arm_pulse();
      if (i == glitch_at) send_glitch_one();
      else send_bit(w[NB-1-i], jit);
    end
    if (stop) send_bit(1'b1, 1'b0);
    cyc(10);
  endtask

  function automatic logic [NB-1:0] expect_word(input logic [NB-1:0] w);
    return w; // first bit sent is w[31]
  endfunction

  task automatic frame_ok(input logic [NB-1:0] w, input bit jit, input int mid_arm,
                          input int glitch_at, input string req);
    int v0, t0;
    v0 = vcnt; t0 = tcnt;
    send_frame(w, NB, 1'b1, jit, mid_arm, glitch_at);
    chk(vcnt == v0 + 1, {req, " valid count"}, NB'(vcnt - v0), 1);
    chk(vword == expect_word(w), {req, " word"}, vword, expect_word(w));
    chk(tcnt == t0, {req, " no timeout"}, NB'(tcnt - t0), 0);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [NB-1:0] w, hold;
    int v0, t0, dly;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; line_i = 1'b1; arm_i = 1'b0;
    cyc(3);
    // R1 under reset
    chk(word_o == '0 && !valid_o && !timeout_o, "R1 in reset", word_o, 0);
    rst_n = 1'b1;
    cyc(5);
    chk(word_o == '0 && !valid_o && !timeout_o, "R1 after release", word_o, 0);

    // R2 line activity without arming
    v0 = vcnt; t0 = tcnt;
    for (int i = 0; i < 40; i++) send_bit(i[0], 1'b0);
    cyc(100);
    chk(vcnt == v0 && tcnt == t0, "R2 no pulses", NB'(vcnt + tcnt - v0 - t0), 0);
    chk(word_o == '0, "R2 word unchanged", word_o, 0);

    // R3/R4 directed
    frame_ok(32'h8000_0000, 1'b0, -1, -1, "R4 msb first");
    frame_ok(32'h0000_0001, 1'b0, -1, -1, "R4 lsb last");
    frame_ok(32'hFFFF_FFFF, 1'b0, -1, -1, "R3 all ones");
    frame_ok(32'h0000_0000, 1'b0, -1, -1, "R3 all zeros");
    frame_ok(32'hA5C3_0F96, 1'b1, -1, -1, "R3 jittered timing");

    // R6 early extra edge inside a one bit (bit 7 is a one)
    frame_ok(32'h0180_0000, 1'b0, -1, 7, "R6 glitch ignored");

    // R8 arm during transfer
    frame_ok(32'h1234_5678, 1'b0, 12, -1, "R8 mid arm ignored");

    // R7 timeout waiting first bit
    v0 = vcnt; t0 = tcnt;
    arm_pulse();
    dly = 0;
    while (tcnt == t0 && dly < 100) begin cyc(1); dly++; end
    chk(dly >= 60 && dly <= 70, "R7 timeout delay", NB'(dly), 64);
    chk(vcnt == v0, "R7 no valid on timeout", NB'(vcnt - v0), 0);

    // R7 timeout mid frame, word held (R5)
    hold = word_o;
    v0 = vcnt; t0 = tcnt;
    send_frame(32'hDEAD_BEEF, 10, 1'b0, 1'b0, -1, -1);
    cyc(80);
    chk(tcnt == t0 + 1, "R7 mid-frame timeout", NB'(tcnt - t0), 1);
    chk(vcnt == v0 && word_o == hold, "R5 word held after timeout", word_o, hold);

    // R7 missing stop bit
    v0 = vcnt; t0 = tcnt;
    send_frame(32'hCAFE_F00D, NB, 1'b0, 1'b0, -1, -1);
    cyc(80);
    chk(tcnt == t0 + 1 && vcnt == v0, "R7 missing stop", NB'(tcnt - t0), 1);

    // R7 recovery after timeout
    frame_ok(32'h5A5A_A5A5, 1'b0, -1, -1, "R7 rearm after timeout");

    // random frames
    for (int k = 0; k < 12; k++) begin
      w = $urandom;
      frame_ok(w, 1'b1, -1, -1, "R3 random frame");
      cyc(int'($urandom % 20));
    end

    // R9 never both
    chk(both == 0, "R9 exclusive pulses", NB'(both), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule